// File: doc/BRIEF.md
# Transport Packet Frame Aligner

This block sits behind a convolutional decoder and turns its raw byte stream into framed transport packets. It searches for a sync value that recurs at the block spacing of the selected mode, then declares lock. From that point it passes the bytes on with a valid strobe, a start-of-block strobe on the first byte of every block, and a steady lock flag. One input selects the mode: a 204-byte block whose sync byte travels on with the data, or a 147-byte block whose sync byte is removed, so that 146 bytes per block go out. In the 147-byte mode the sync value comes from an input.

The decoder ahead of it can leave the whole stream bit-inverted. The aligner therefore also accepts the complement of the sync value. If it locks on complemented sync bytes, it inverts every byte it emits, so the next stage always sees true data. Once locked, the block tolerates a few corrupted sync bytes. After a run of misses it returns to search.

Top module: `pkt_frame_aligner`

## Requirements
- R1: After reset, out_valid, out_sob and locked are all 0.
- R2: locked rises at the clock edge that takes in the third sync match of a chain in which each match follows the one before by exactly one block length; after two matches it is still 0. Acquisition after a loss of lock again needs three such matches.
- R3: With mode_dss=0 the block length is 204 bytes and the pattern is 0x47. The sync byte is emitted as the first byte of its block with out_sob=1 and value 0x47, and exactly 204 bytes are emitted from one out_sob to the next.
- R4: With mode_dss=1 the block length is 147 bytes. The sync byte is never emitted, out_sob marks the byte that follows it, and exactly 146 bytes are emitted per block.
- R5: A byte equal to the bitwise complement of the pattern (0xB8 when mode_dss=0) counts as an inverted match. A chain of inverted matches locks the block, and every emitted byte is then complemented, so the true values appear at out_byte. The matches in one chain must all have the same polarity.
- R6: out_valid is 0 whenever locked is 0.
- R7: While locked, lock is dropped at the fourth consecutive expected sync position that does not hold a same-polarity match, and the byte at that position is not emitted. Three misses keep the lock, and a match clears the miss count.
- R8: A cycle with in_valid=0 is ignored. It does not advance the position count, out_valid is 0 in the following cycle, and locked does not change.
- R9: With mode_dss=1 the pattern is the value on dss_sync, and its complement is the inverted match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_dss | input | 1 | 0 selects 204-byte blocks, 1 selects 147-byte blocks with sync removal |
| dss_sync | input | 8 | Sync pattern used when mode_dss=1 |
| in_valid | input | 1 | in_byte carries a byte this cycle |
| in_byte | input | 8 | Decoded input byte |
| out_valid | output | 1 | out_byte carries an aligned byte |
| out_byte | output | 8 | Aligned byte, polarity corrected |
| out_sob | output | 1 | First emitted byte of a block |
| locked | output | 1 | Block alignment held |

## Verification
The block-length property takes mode_dss and dss_sync as fixed for as long as lock lasts, since a mode change in mid-lock would alter the spacing between start-of-block strobes. The stimulus changes both only while reset is asserted. It builds payload bytes that never equal either pattern or their complements, so the lock point and the emitted sequence follow from packet and byte indices alone. The idle cycles inserted into the stream carry the sync value on in_byte, which shows that a byte without in_valid cannot form or break a match.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

   typedef enum logic {
      ST_SEARCH = 1'b0,
      ST_LOCK   = 1'b1
   } align_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/align_sync_match.sv
module align_sync_match #(
   parameter int DATA_W     = 8,
   parameter bit ACCEPT_INV = 1'b1
) (
   input  logic [DATA_W-1:0] cur_byte,
   input  logic [DATA_W-1:0] pattern,
   output logic              hit_true,
   output logic              hit_inv
);

   assign hit_true = (cur_byte == pattern);

   generate
      if (ACCEPT_INV) begin : g_inv
         assign hit_inv = (cur_byte == ~pattern);
      end else begin : g_no_inv
         assign hit_inv = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
   import aligner_pkg::*;
#(
   parameter int LEN_A       = 204,
   parameter int LEN_B       = 147,
   parameter int ACQ_HITS    = 3,
   parameter int LOSS_MISSES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic mode_dss,
   input  logic hit_true,
   input  logic hit_inv,
   output logic locked,
   output logic pol,
   output logic emit,
   output logic sob
);

   localparam int LMAX = max2(LEN_A, LEN_B);
   localparam int PW   = $clog2(LMAX);
   localparam int HW   = $clog2(ACQ_HITS + 1);
   localparam int MW   = $clog2(LOSS_MISSES + 1);

   align_state_e   st_q, st_n;
   logic [PW-1:0]  pos_q, pos_n, pos_inc, last_pos;
   logic [HW-1:0]  hits_q, hits_n;
   logic [MW-1:0]  miss_q, miss_n;
   logic           pol_q, pol_n;
   logic           at_slot, same, any_hit, enter, drop;

   assign last_pos = mode_dss ? PW'(LEN_B - 1) : PW'(LEN_A - 1);
   assign pos_inc  = (pos_q == last_pos) ? '0 : pos_q + 1'b1;
   assign at_slot  = (pos_q == '0);
   assign same     = pol_q ? hit_inv : hit_true;
   assign any_hit  = hit_true | hit_inv;

   always_comb begin
      st_n   = st_q;
      pos_n  = pos_q;
      hits_n = hits_q;
      miss_n = miss_q;
      pol_n  = pol_q;
      enter  = 1'b0;
      drop   = 1'b0;
      if (in_valid) begin
         pos_n = pos_inc;
         if (st_q == ST_SEARCH) begin
            if (hits_q == '0 || (at_slot && !same)) begin
               if (any_hit) begin
                  hits_n = HW'(1);
                  pol_n  = hit_inv;
                  pos_n  = PW'(1);
               end else begin
                  hits_n = '0;
                  pos_n  = '0;
               end
            end else if (at_slot) begin
               if (hits_q == HW'(ACQ_HITS - 1)) begin
                  enter  = 1'b1;
                  st_n   = ST_LOCK;
                  hits_n = '0;
                  miss_n = '0;
               end else begin
                  hits_n = hits_q + 1'b1;
               end
            end
         end else if (at_slot) begin
            if (same) begin
               miss_n = '0;
            end else if (miss_q == MW'(LOSS_MISSES - 1)) begin
               drop   = 1'b1;
               st_n   = ST_SEARCH;
               hits_n = '0;
               pos_n  = '0;
            end else begin
               miss_n = miss_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_SEARCH;
         pos_q  <= '0;
         hits_q <= '0;
         miss_q <= '0;
         pol_q  <= 1'b0;
      end else begin
         st_q   <= st_n;
         pos_q  <= pos_n;
         hits_q <= hits_n;
         miss_q <= miss_n;
         pol_q  <= pol_n;
      end
   end

   assign emit   = in_valid && (((st_q == ST_LOCK) && !drop) || enter)
                   && !(mode_dss && at_slot);
   assign sob    = mode_dss ? (pos_q == PW'(1)) : at_slot;
   assign pol    = pol_q;
   assign locked = (st_q == ST_LOCK);

endmodule

// File: rtl/align_out.sv
module align_out #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emit,
   input  logic              sob,
   input  logic              pol,
   input  logic              st_locked_n,
   input  logic [DATA_W-1:0] cur_byte,
   output logic              out_valid,
   output logic              out_sob,
   output logic [DATA_W-1:0] out_byte,
   output logic              locked
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sob   <= 1'b0;
         out_byte  <= '0;
         locked    <= 1'b0;
      end else begin
         out_valid <= emit;
         out_sob   <= emit && sob;
         locked    <= st_locked_n;
         if (emit) out_byte <= cur_byte ^ {DATA_W{pol}};
      end
   end

endmodule

// File: rtl/pkt_frame_aligner.sv
module pkt_frame_aligner #(
   parameter int          DATA_W      = 8,
   parameter int          LEN_A       = 204,
   parameter int          LEN_B       = 147,
   parameter logic [7:0]  SYNC_A      = 8'h47,
   parameter int          ACQ_HITS    = 3,
   parameter int          LOSS_MISSES = 4,
   parameter bit          ACCEPT_INV  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_dss,
   input  logic [DATA_W-1:0] dss_sync,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_sob,
   output logic              locked
);

   generate
      if (LEN_A < 4 || LEN_B < 4) begin : g_bad_len
         $error("block lengths must be at least 4");
      end
      if (ACQ_HITS < 2) begin : g_bad_acq
         $error("ACQ_HITS must be at least 2");
      end
      if (LOSS_MISSES < 1) begin : g_bad_loss
         $error("LOSS_MISSES must be at least 1");
      end
      if (DATA_W != 8) begin : g_bad_w
         $error("DATA_W must be 8");
      end
   endgenerate

   logic [DATA_W-1:0] pattern;
   logic hit_true, hit_inv, st_locked, pol, emit, sob;

   assign pattern = mode_dss ? dss_sync : DATA_W'(SYNC_A);

   align_sync_match #(.DATA_W(DATA_W), .ACCEPT_INV(ACCEPT_INV)) u_match (
      .cur_byte (in_byte),
      .pattern  (pattern),
      .hit_true (hit_true),
      .hit_inv  (hit_inv)
   );

   align_ctrl #(
      .LEN_A(LEN_A), .LEN_B(LEN_B),
      .ACQ_HITS(ACQ_HITS), .LOSS_MISSES(LOSS_MISSES)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .mode_dss (mode_dss),
      .hit_true (hit_true),
      .hit_inv  (hit_inv),
      .locked   (st_locked),
      .pol      (pol),
      .emit     (emit),
      .sob      (sob)
   );

   logic st_locked_n;
   assign st_locked_n = u_ctrl.st_n == aligner_pkg::ST_LOCK;

   align_out #(.DATA_W(DATA_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .emit        (emit),
      .sob         (sob),
      .pol         (pol),
      .st_locked_n (st_locked_n),
      .cur_byte    (in_byte),
      .out_valid   (out_valid),
      .out_sob     (out_sob),
      .out_byte    (out_byte),
      .locked      (locked)
   );

   logic unused_locked;
   assign unused_locked = st_locked;

endmodule

// File: rtl/pkt_frame_aligner_chk.sv
module pkt_frame_aligner_chk #(
   parameter int LEN_A = 204,
   parameter int LEN_B = 147
) (
   input logic clk,
   input logic rst_n,
   input logic mode_dss,
   input logic in_valid,
   input logic out_valid,
   input logic out_sob,
   input logic locked
);

   int  cnt_q;
   logic seen_q;
   logic bad_len;
   int  exp_len;

   assign exp_len = mode_dss ? (LEN_B - 1) : LEN_A;
   assign bad_len = out_valid && out_sob && seen_q && (cnt_q != exp_len);

   always_ff @(posedge clk) begin
      if (!rst_n || !locked) begin
         cnt_q  <= 0;
         seen_q <= 1'b0;
      end else if (out_valid && out_sob) begin
         cnt_q  <= 1;
         seen_q <= 1'b1;
      end else if (out_valid) begin
         cnt_q  <= cnt_q + 1;
      end
   end

   p_quiet_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> locked);

   p_sob_with_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_sob |-> out_valid);

   p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(locked)));

   p_lock_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(in_valid));

   p_drop_on_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(in_valid));

   // R3 and R4: emitted bytes per block
   p_block_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_len);

endmodule

bind pkt_frame_aligner pkt_frame_aligner_chk #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_dss  (mode_dss),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_sob   (out_sob),
   .locked    (locked)
);

// File: tb/tb_pkt_frame_aligner.sv
`timescale 1ns/1ps
module tb_pkt_frame_aligner;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_dss = 1'b0;
   logic [7:0] dss_sync = 8'h1D;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_sob, locked;
   logic [7:0] out_byte;

   always #2 clk = ~clk;

   pkt_frame_aligner dut (
      .clk(clk), .rst_n(rst_n), .mode_dss(mode_dss), .dss_sync(dss_sync),
      .in_valid(in_valid), .in_byte(in_byte), .out_valid(out_valid),
      .out_byte(out_byte), .out_sob(out_sob), .locked(locked)
   );

   int   checks = 0;
   int   failures = 0;
   int   out_cnt = 0;
   logic chk_vals = 1'b0;
   logic cur_dss = 1'b0;
   logic applied_v = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pay(input int p, input int i);
      logic [7:0] v;
      v = 8'((p * 31 + i * 5 + 3) & 255);
      if (v == 8'h47 || v == 8'hB8 || v == 8'h1D || v == 8'hE2 ||
          v == 8'hA3 || v == 8'h5C) v = 8'h00;
      return v;
   endfunction

   always @(posedge clk) applied_v <= in_valid;

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         int lo, q, r, idx;
         logic [7:0] e;
         chk(applied_v, "R8 output after idle", 1, 0);
         chk(locked, "R6 output while searching", 0, 1);
         if (chk_vals) begin
            lo  = cur_dss ? 146 : 204;
            q   = out_cnt / lo;
            r   = out_cnt % lo;
            idx = cur_dss ? r + 1 : r;
            e   = (!cur_dss && idx == 0) ? 8'h47 : pay(2 + q, idx);
            chk(out_byte == e, cur_dss ? "R4 R5 byte" : "R3 R5 byte", out_byte, e);
            chk(out_sob == (r == 0), "R3 R4 sob", out_sob, (r == 0));
         end
         out_cnt++;
      end
   end

   task automatic drive(input logic [7:0] b, input logic v);
      @(negedge clk);
      in_valid = v;
      in_byte  = b;
   endtask

   task automatic settle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_reset(input logic dss, input logic [7:0] sv);
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      mode_dss = dss;
      dss_sync = sv;
      cur_dss  = dss;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      out_cnt = 0;
      chk(!out_valid && !out_sob && !locked, "R1 reset state",
          {out_valid, out_sob, locked}, 0);
   endtask

   task automatic run(input logic dss, input logic inv, input logic gaps);
      logic [7:0] sv, b;
      int len, k;
      sv  = inv ? 8'hA3 : 8'h1D;
      do_reset(dss, sv);
      chk_vals = 1'b1;
      len = dss ? 147 : 204;
      k   = 0;
      for (int p = 0; p < 5; p++) begin
         for (int i = 0; i < len; i++) begin
            if (p == 2 && i == 0) begin
               settle();
               chk(!locked, "R2 two matches", locked, 0);
            end
            if (gaps && (k % 5 == 4)) begin
               drive(dss ? sv : 8'h47, 1'b0);
               k++;
            end
            b = (i == 0) ? (dss ? sv : 8'h47) : pay(p, i);
            if (inv) b = ~b;
            drive(b, 1'b1);
            k++;
            if (p == 2 && i == 0) begin
               settle();
               chk(locked, dss ? "R2 R9 third match" : "R2 third match", locked, 1);
            end
         end
      end
      settle();
      settle();
      chk(locked, "R2 lock held", locked, 1);
      chk(out_cnt == 3 * (dss ? 146 : 204), dss ? "R4 R9 count" : "R3 count",
          out_cnt, 3 * (dss ? 146 : 204));
   endtask

   task automatic loss_run();
      logic [7:0] b;
      do_reset(1'b0, 8'h1D);
      chk_vals = 1'b0;
      for (int p = 0; p < 14; p++) begin
         for (int i = 0; i < 204; i++) begin
            if (i == 0) begin
               b = ((p >= 3 && p <= 5) || (p >= 7 && p <= 10)) ? 8'h00 : 8'h47;
            end else begin
               b = pay(p, i);
            end
            drive(b, 1'b1);
            if (p == 10 && i == 0) begin
               settle();
               chk(!locked, "R7 fourth miss drops", locked, 0);
            end
            if (p == 13 && i == 0) begin
               settle();
               chk(locked, "R2 reacquire", locked, 1);
            end
         end
         if (p == 5 || p == 9) begin
            settle();
            chk(locked, "R7 three misses kept", locked, 1);
         end
         if (p == 12) begin
            settle();
            chk(!locked, "R2 reacquire needs three", locked, 0);
         end
      end
      settle();
      settle();
      chk(out_cnt == 8 * 204 + 204, "R7 emitted count", out_cnt, 8 * 204 + 204);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      for (int m = 0; m < 8; m++) begin
         run(m[0], m[1], m[2]);
      end
      loss_run();
      finish_up();
   end

   initial begin
      #(4 * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_up();
   end

endmodule